// File: doc/BRIEF.md
# Audio Playback Sample FIFO with DMA Request

This block buffers outgoing audio samples for a DAC path. A host, usually a DMA engine, writes samples one word at a time into a data port. Each sample is widened to 24 bits as it is written and stored in a 64-entry FIFO. On every sample tick the block hands one frame to the downstream DAC interface. A frame is either one entry driving both channels (mono) or a left/right pair of entries (stereo, left written first).

A DMA request is raised once the free space reaches a programmable trigger level. It is held until the free space falls below a threshold chosen by a 2-bit clear code, so requests have hysteresis. The request is gated by its own enable bit: clearing that bit stops requests without disturbing the stored samples. A flush bit empties the FIFO.

When a tick finds too few entries, the output is either zeros or the last frame, as selected by a control bit. An underrun flag then sets and stays set. A write to a full FIFO is dropped and sets an overrun flag, which is also sticky. The free-space count and both flags are visible as status.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the FIFO is empty and `free_o` is 64. The `drq_o`, `out_vld_o`, `ovr_o` and `udr_o` outputs are 0, and `left_o` and `right_o` are 0.
- R2: A control write (`ctrl_we_i`) with bit 0 set empties the FIFO, so `free_o` reads 64 on the next cycle. A data write in the same cycle is discarded. Bit 0 is not stored. All other fields are taken from control bits 13:1.
- R3: A data write while 64 entries are held is dropped and leaves the contents unchanged. The count never exceeds 64. It sets `ovr_o`, which stays set until a status write (`sts_we_i`) with bit 1 set. If the two happen in the same cycle, the set wins.
- R4: With the request enable (control bit 1) set and no request active, `drq_o` rises in the cycle after one in which the free space is at least the trigger level in control bits 7:2.
- R5: While a request is active and enabled, `drq_o` stays high until the cycle after the free space falls below 4*(clear code+1), where the clear code is control bits 9:8. Code 3 gives 16.
- R6: With the request enable clear, `drq_o` is low from the next cycle on. Clearing the enable does not change the FIFO contents or `free_o`.
- R7: With control bit 11 clear, a write stores `wr_data_i[15:0]` in output bits 23:8. Bits 7:0 are zero when control bit 12 is 0, and copies of bit 15 when control bit 12 is 1. With control bit 11 set, the stored sample is `wr_data_i[31:8]` and bit 12 has no effect. Widening uses the control value held before the write cycle.
- R8: In stereo mode (control bit 10 clear) a tick with at least two entries removes two entries. The older one goes to `left_o` and the newer one to `right_o`.
- R9: In mono mode (control bit 10 set) a tick with at least one entry removes one entry and drives it on both `left_o` and `right_o`.
- R10: A tick with fewer entries than a frame needs removes nothing and sets `udr_o`. The outputs go to zero when control bit 13 is 0 and keep the previous frame when it is 1. `udr_o` stays set until a status write with bit 0 set.
- R11: `out_vld_o` is high exactly in the cycle after each tick. `left_o` and `right_o` change only in that cycle.
- R12: A write and a tick in the same cycle are both judged on the entry count at the start of that cycle. A sample written into an empty FIFO in a tick cycle is not played by that tick, and the next count is the old count plus the accepted write minus the entries removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Data write strobe |
| wr_data_i | input | 32 | Sample data word |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 32 | Control word: 0 flush, 1 request enable, 7:2 trigger level, 9:8 clear code, 10 mono, 11 24-bit, 12 MSB fill, 13 repeat last on underrun |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 2 | Writing 1 clears: bit 0 underrun, bit 1 overrun |
| tick_i | input | 1 | Sample tick, one frame per pulse |
| left_o | output | 24 | Left channel sample |
| right_o | output | 24 | Right channel sample |
| out_vld_o | output | 1 | Frame updated this cycle |
| drq_o | output | 1 | DMA request |
| free_o | output | 7 | Free entries |
| ovr_o | output | 1 | Sticky overrun flag |
| udr_o | output | 1 | Sticky underrun flag |

## Verification
A host write and a sample tick can land in the same cycle. So can a flush and a write, and a flag set and its clear. Directed cycles force each pairing at the critical fill levels: an empty FIFO, one entry in stereo, and a full FIFO. A long random run then mixes writes, ticks, status clears and rare reconfigurations. After every cycle, a bench queue model predicts the fill level, the frame values, the request state and both flags, and each port is compared with it.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;
  localparam int SMP_W  = 24;
  localparam int WORD_W = 32;

  // control bits 13:1, msb first
  typedef struct packed {
    logic       rep_last;
    logic       msb_fill;
    logic       w24;
    logic       mono;
    logic [1:0] clr_code;
    logic [5:0] trig;
    logic       drq_en;
  } tx_cfg_t;

  function automatic logic [6:0] clr_thr(input logic [1:0] code);
    return 7'({code, 2'b00}) + 7'd4;
  endfunction
endpackage

// File: rtl/sample_widen.sv
`timescale 1ns/1ps
module sample_widen
  import audio_tx_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  logic              w24_i,
  input  logic              msb_fill_i,
  output logic [SMP_W-1:0]  smp_o
);
  localparam int PAD_W = SMP_W - 16;

  always_comb begin
    if (w24_i)           smp_o = data_i[WORD_W-1 -: SMP_W];
    else if (msb_fill_i) smp_o = {data_i[15:0], {PAD_W{data_i[15]}}};
    else                 smp_o = {data_i[15:0], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/tx_fifo_mem.sv
`timescale 1ns/1ps
module tx_fifo_mem #(
  parameter  int DEPTH = 64,
  parameter  int DW    = 24,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [1:0]    pop_i,
  output logic [DW-1:0] head0_o,
  output logic [DW-1:0] head1_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(1);
      rd_ptr_q <= rd_ptr_q + AW'(pop_i);
      count_q  <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head0_o = mem_q[rd_ptr_q];
  assign head1_o = mem_q[rd_ptr_q + AW'(1)];
  assign count_o = count_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_flush_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);
  assert_pop_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CW'(pop_i) <= count_q);
endmodule

// File: rtl/drq_gen.sv
`timescale 1ns/1ps
module drq_gen
  import audio_tx_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [5:0]    trig_i,
  input  logic [1:0]    clr_code_i,
  input  logic [CW-1:0] free_i,
  output logic          drq_o
);
  logic [CW-1:0] thr;
  logic          drq_q;

  assign thr = CW'(clr_thr(clr_code_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drq_q <= 1'b0;
    else         drq_q <= en_i && (drq_q ? (free_i >= thr) : (free_i >= CW'(trig_i)));
  end

  assign drq_o = drq_q;

  assert_drq_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drq_o);
  assert_drq_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && en_i && free_i >= thr) |=> drq_o);
  assert_drq_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drq_o && free_i < thr) |=> !drq_o);
endmodule

// File: rtl/audio_tx_fifo.sv
`timescale 1ns/1ps
module audio_tx_fifo
  import audio_tx_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ctrl_we_i,
  input  logic [31:0]       ctrl_wdata_i,
  input  logic              sts_we_i,
  input  logic [1:0]        sts_wdata_i,
  input  logic              tick_i,
  output logic [SMP_W-1:0]  left_o,
  output logic [SMP_W-1:0]  right_o,
  output logic              out_vld_o,
  output logic              drq_o,
  output logic [CW-1:0]     free_o,
  output logic              ovr_o,
  output logic              udr_o
);
  tx_cfg_t          cfg_q;
  logic             flush, push, can_pop, full;
  logic [1:0]       need, pop;
  logic [CW-1:0]    count;
  logic [SMP_W-1:0] smp, head0, head1;
  logic             vld_q, ovr_q, udr_q;
  logic [SMP_W-1:0] left_q, right_q;

  assign flush   = ctrl_we_i & ctrl_wdata_i[0];
  assign full    = count >= CW'(DEPTH);
  assign push    = wr_en_i & ~full;
  assign need    = cfg_q.mono ? 2'd1 : 2'd2;
  assign can_pop = count >= CW'(need);
  assign pop     = (tick_i & can_pop) ? need : 2'd0;
  assign free_o  = CW'(DEPTH) - count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (ctrl_we_i) cfg_q <= tx_cfg_t'(ctrl_wdata_i[13:1]);
  end

  sample_widen u_widen (
    .data_i     (wr_data_i),
    .w24_i      (cfg_q.w24),
    .msb_fill_i (cfg_q.msb_fill),
    .smp_o      (smp)
  );

  tx_fifo_mem #(.DEPTH(DEPTH), .DW(SMP_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (smp),
    .pop_i       (pop),
    .head0_o     (head0),
    .head1_o     (head1),
    .count_o     (count)
  );

  drq_gen #(.CW(CW)) u_drq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg_q.drq_en),
    .trig_i     (cfg_q.trig),
    .clr_code_i (cfg_q.clr_code),
    .free_i     (free_o),
    .drq_o      (drq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
      vld_q   <= 1'b0;
      ovr_q   <= 1'b0;
      udr_q   <= 1'b0;
    end else begin
      vld_q <= tick_i;
      if (tick_i) begin
        if (can_pop) begin
          left_q  <= head0;
          right_q <= cfg_q.mono ? head0 : head1;
        end else if (!cfg_q.rep_last) begin
          left_q  <= '0;
          right_q <= '0;
        end
      end
      // set beats clear in the same cycle
      ovr_q <= (ovr_q & ~(sts_we_i & sts_wdata_i[1])) | (wr_en_i & full);
      udr_q <= (udr_q & ~(sts_we_i & sts_wdata_i[0])) | (tick_i & ~can_pop);
    end
  end

  assign left_o    = left_q;
  assign right_o   = right_q;
  assign out_vld_o = vld_q;
  assign ovr_o     = ovr_q;
  assign udr_o     = udr_q;

  assert_ovr_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && free_o == '0) |=> ovr_o);
  assert_udr_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !can_pop && !cfg_q.rep_last) |=> (left_o == '0 && right_o == '0 && udr_o));
  assert_udr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !can_pop && cfg_q.rep_last) |=> ($stable(left_o) && $stable(right_o)));
  assert_vld_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> out_vld_o);
  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(left_o) && $stable(right_o) && !out_vld_o));
  assert_mono_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cfg_q.mono && can_pop) |=> left_o == right_o);
  assert_push_pop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tick_i && !flush && !cfg_q.mono && count >= CW'(2) && !full)
      |=> free_o == $past(free_o) + CW'(1));
endmodule

// File: tb/audio_tx_fifo_bench.sv
`timescale 1ns/1ps
module audio_tx_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, ctrl_we = 1'b0, sts_we = 1'b0, tick = 1'b0;
  logic [31:0] wr_data = '0, ctrl_wd = '0;
  logic [1:0]  sts_wd = '0;
  logic [23:0] left, right;
  logic        vld, drq, ovr, udr;
  logic [6:0]  free;

  int vectors = 0, errors = 0;

  // model state
  int          q[$];
  logic [31:0] mctl = '0;
  logic [23:0] ml = '0, mr = '0;
  logic        mvld = 0, mdrq = 0, movr = 0, mudr = 0;

  always #2.5 clk = ~clk;

  audio_tx_fifo u_audio_tx_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .sts_we_i(sts_we), .sts_wdata_i(sts_wd),
    .tick_i(tick), .left_o(left), .right_o(right), .out_vld_o(vld), .drq_o(drq),
    .free_o(free), .ovr_o(ovr), .udr_o(udr)
  );

  function automatic logic [31:0] mk(input bit fl, input bit en, input int trig, input int clr,
                                     input bit mono, input bit w24, input bit msb, input bit rep);
    return {18'd0, rep, msb, w24, mono, 2'(clr), 6'(trig), en, fl};
  endfunction

  function automatic logic [23:0] widen(input logic [31:0] d, input logic [31:0] c);
    if (c[11]) return d[31:8];
    if (c[12]) return {d[15:0], {8{d[15]}}};
    return {d[15:0], 8'h00};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [31:0] wd, input bit cw, input logic [31:0] cd,
                     input bit tk, input bit sw, input logic [1:0] sd, input string tag);
    int cnt, need, freep, thr;
    @(negedge clk);
    wr_en = we; wr_data = wd; ctrl_we = cw; ctrl_wd = cd; tick = tk; sts_we = sw; sts_wd = sd;
    @(posedge clk);
    cnt   = q.size();
    freep = 64 - cnt;
    need  = mctl[10] ? 1 : 2;
    thr   = 4 * (int'(mctl[9:8]) + 1);
    mdrq  = mctl[1] && (mdrq ? (freep >= thr) : (freep >= int'(mctl[7:2])));
    mvld  = tk;
    if (sw && sd[0]) mudr = 0;
    if (sw && sd[1]) movr = 0;
    if (tk) begin
      if (cnt >= need) begin
        ml = 24'(q.pop_front());
        mr = mctl[10] ? ml : 24'(q.pop_front());
      end else begin
        mudr = 1;
        if (!mctl[13]) begin ml = 0; mr = 0; end
      end
    end
    if (we) begin
      if (cnt >= 64) movr = 1;
      else q.push_back(int'(widen(wd, mctl)));
    end
    if (cw && cd[0]) q.delete();
    if (cw) mctl = {18'd0, cd[13:1], 1'b0};
    #1;
    chk(tag, "left", int'(left), int'(ml));
    chk(tag, "right", int'(right), int'(mr));
    chk(tag, "vld", int'(vld), int'(mvld));
    chk(tag, "drq", int'(drq), int'(mdrq));
    chk(tag, "free", int'(free), 64 - q.size());
    chk(tag, "ovr", int'(ovr), int'(movr));
    chk(tag, "udr", int'(udr), int'(mudr));
  endtask

  task automatic wr(input logic [31:0] d, input string tag);  cyc(1, d, 0, 0, 0, 0, 0, tag); endtask
  task automatic ctl(input logic [31:0] c, input string tag); cyc(0, 0, 1, c, 0, 0, 0, tag); endtask
  task automatic tk1(input string tag);                       cyc(0, 0, 0, 0, 1, 0, 0, tag); endtask
  task automatic idle(input string tag);                      cyc(0, 0, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk("R1", "free", int'(free), 64);
    chk("R1", "drq", int'(drq), 0);
    chk("R1", "flags", int'({ovr, udr, vld}), 0);
    chk("R1", "left", int'(left), 0);
    idle("R1"); idle("R1");

    // request hysteresis
    ctl(mk(0, 1, 32, 3, 0, 0, 0, 0), "R4");
    idle("R4"); idle("R4");
    for (int i = 0; i < 49; i++) wr(32'(i + 1), "R5");
    idle("R5"); idle("R5");
    ctl(mk(0, 1, 40, 1, 0, 0, 0, 0), "R5");
    for (int i = 0; i < 10; i++) tk1("R5");
    idle("R5");
    // stop keeps contents
    ctl(mk(0, 0, 32, 3, 0, 0, 0, 0), "R6");
    idle("R6"); idle("R6");
    // flush with a same-cycle write
    cyc(1, 32'h5555, 1, mk(1, 0, 32, 3, 0, 0, 0, 0), 0, 0, 0, "R2");
    idle("R2");
    // fill past full, then clear overrun
    for (int i = 0; i < 66; i++) wr(32'(i * 7), "R3");
    cyc(1, 32'h1, 0, 0, 0, 1, 2'b10, "R3");
    cyc(0, 0, 0, 0, 0, 1, 2'b10, "R3");
    idle("R3");
    // widening and stereo order
    ctl(mk(1, 0, 0, 0, 0, 0, 0, 0), "R7");
    wr(32'hFFFF_8001, "R7"); wr(32'h0000_7FFF, "R7");
    tk1("R8"); idle("R8");
    ctl(mk(0, 0, 0, 0, 0, 0, 1, 0), "R7");
    wr(32'h0000_80F0, "R7"); wr(32'h0000_0012, "R7");
    tk1("R7"); idle("R7");
    ctl(mk(0, 0, 0, 0, 0, 1, 1, 0), "R7");
    wr(32'hABCD_EF55, "R7"); wr(32'h1234_5600, "R7");
    tk1("R7"); idle("R7");
    // mono
    ctl(mk(0, 0, 0, 0, 1, 0, 0, 0), "R9");
    wr(32'h0000_4321, "R9"); wr(32'h0000_8765, "R9");
    tk1("R9"); tk1("R9"); idle("R9");
    // underrun zero, then hold
    tk1("R10");
    cyc(0, 0, 0, 0, 0, 1, 2'b01, "R10");
    ctl(mk(0, 0, 0, 0, 0, 0, 0, 1), "R10");
    wr(32'h0000_0A0A, "R10"); wr(32'h0000_0B0B, "R10");
    tk1("R10"); tk1("R10");
    wr(32'h0000_0C0C, "R10"); tk1("R10");
    cyc(0, 0, 0, 0, 1, 1, 2'b01, "R10");
    cyc(0, 0, 0, 0, 0, 1, 2'b01, "R10");
    // same-cycle push and pop
    ctl(mk(1, 0, 0, 0, 0, 0, 0, 0), "R12");
    cyc(1, 32'h0000_1111, 0, 0, 1, 0, 0, "R12");
    wr(32'h0000_2222, "R12"); wr(32'h0000_3333, "R12");
    cyc(1, 32'h0000_4444, 0, 0, 1, 0, 0, "R12");
    cyc(0, 0, 0, 0, 1, 0, 0, "R12");
    idle("R11");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      bit we, cw, tk, sw;
      logic [31:0] cd;
      we = ($urandom % 100) < 55;
      tk = ($urandom % 100) < 20;
      sw = ($urandom % 100) < 4;
      cw = ($urandom % 100) < 2;
      cd = mk(($urandom % 4) == 0, ($urandom % 8) != 0, int'($urandom % 64), int'($urandom % 4),
              $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
      cyc(we, $urandom, cw, cd, tk, sw, 2'($urandom), "R12");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule